// File: doc/BRIEF.md
# Issue-Driven Computation Unit with Operand and Result Handshakes

This block sits between an instruction issuer and a small arithmetic unit. A single-cycle issue pulse hands it an operation; the unit captures the operation fields, raises busy, and then collects each source operand through its own request/grant pair. Once every operand it needs is in hand, the arithmetic result and an optional condition-flag word are computed and registered. Each produced output is then offered to the register file through a separate request/grant pair. Busy stays high until all of this has finished.

Operand ports can be skipped. This happens for three reasons: the issuer sets a per-port read-mask bit, the first operand is forced to zero, or the second operand is replaced by an immediate value. Output ports that the operation does not produce raise no write request. Instead, they are flagged on a write-mask output. The issuer keeps the read-mask steady for the whole busy period. It may change every other operation field right after the issue cycle.

Top module: `cu_issue_unit`

## Requirements
- R1: When issue_i is high while the unit is idle, the op code is captured together with inv_a_i, zero_a_i, imm_ok_i, imm_i and rc_i, and busy_o is high from the next cycle. Op codes are 0 NOP, 1 ADD, 2 SUB and 3 SEXT. Changing these inputs after the issue cycle has no effect on the operation.
- R2: busy_o is low in any cycle where issue_i is high and never rises unless issue_i was high in the cycle before. While busy_o is low, no read or write request is high.
- R3: Every needed operand port raises its read request (bit 0 = operand A, bit 1 = operand B) in the cycle after issue. The request stays high for as many cycles as the grant is delayed.
- R4: A grant may arrive in the first cycle of its request. The operand data is taken only in the grant cycle. The request is low from the next cycle and stays low for the rest of the operation.
- R5: No read request is raised on a port whose rdmask_i bit is set, and that operand reads as zero. Operand A raises no request when zero_a is set and then reads as zero. Operand B raises no request when imm_ok is set and then takes imm.
- R6: rdmask_i is used live rather than latched, and the issuer holds it for the whole busy period.
- R7: Output port 0 (result) is produced for every op except NOP. Output port 1 (flags) is produced only when rc is set and the op is not NOP. During busy, wrmask_o has a bit set for each unproduced port, and a port never has its write request and wrmask_o bit high together. A NOP with both reads masked raises no request at all.
- R8: A write request stays high with stable data until its grant, whatever the delay, and the data is valid in the grant cycle.
- R9: A equals (zero_a or masked ? 0 : operand A) and is bitwise inverted when inv_a is set. ADD gives A+B, SUB gives A-B, and SEXT sign-extends the low 8 bits of A, all modulo 2^WIDTH. The flags word carries 3'b100 for a positive result, 3'b010 for a negative one (top bit set) and 3'b001 for zero, in its low bits.
- R10: Let the reference cycle be the last read grant cycle, or the issue cycle if no operand is read. Write requests rise two cycles after the reference cycle. busy_o is low in the cycle after the last write grant. With no output produced, busy_o is low three cycles after the reference cycle. Every operation ends within 50 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | 2 | Operation code |
| inv_a_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Force operand A to zero, skip its read |
| imm_ok_i | input | 1 | Use immediate as operand B, skip its read |
| imm_i | input | WIDTH | Immediate value |
| rc_i | input | 1 | Produce the flags output |
| rdmask_i | input | 2 | Per-port read skip, held while busy |
| src_go_i | input | 2 | Read grants |
| src_data_i | input | 2*WIDTH | Operand data, port i in slice i |
| busy_o | output | 1 | Operation in progress |
| src_req_o | output | 2 | Read requests |
| dst_req_o | output | 2 | Write requests |
| dst_go_i | input | 2 | Write grants |
| wrmask_o | output | 2 | Unproduced outputs during busy |
| dst_data_o | output | 2*WIDTH | Result data, port j in slice j |

## Verification
Read requests are due in the first cycle after issue. Write requests are due two cycles after the last read grant, or after the issue cycle when no read is needed. busy_o is due low one cycle after the last write grant, or three cycles after the reference cycle when nothing is written. The bench drives every input and samples every output on the falling edge. It numbers the cycles from the issue cycle and records the cycle of each grant and each first request, then compares those cycle numbers against these offsets. Grants come after programmed per-port delays. Operand data is present only in grant cycles, and the operation fields are scrambled right after issue, so a wrong capture cycle shows up as a wrong result.

// File: rtl/cu_pkg.sv
package cu_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned NUM_DST = 2;
  localparam int unsigned SRC_A   = 0;
  localparam int unsigned SRC_B   = 1;
  localparam int unsigned DST_RES = 0;
  localparam int unsigned DST_FLG = 1;
  localparam int unsigned FLAG_W  = 3;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_SEXT = 2'd3
  } op_e;

  typedef struct packed {
    op_e  op;
    logic inv_a;
    logic zero_a;
    logic imm_ok;
    logic rc;
  } ctl_t;
endpackage

// File: rtl/cu_rd_port.sv
module cu_rd_port #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             skip,
  input  logic             go,
  input  logic [WIDTH-1:0] data,
  output logic             req,
  output logic             ready,
  output logic [WIDTH-1:0] q
);
  logic             taken_q, taken_d;
  logic [WIDTH-1:0] val_q, val_d;
  logic             grab;

  always_comb begin
    req   = busy & ~skip & ~taken_q;
    ready = taken_q | skip;
    grab  = req & go;
    q     = val_q;
  end

  always_comb begin
    taken_d = taken_q;
    val_d   = val_q;
    if (start) begin
      taken_d = 1'b0;
      val_d   = '0;
    end else if (grab) begin
      taken_d = 1'b1;
      val_d   = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      val_q   <= '0;
    end else begin
      taken_q <= taken_d;
      if (start | grab) val_q <= val_d;
    end
  end
endmodule

// File: rtl/cu_alu.sv
module cu_alu
  import cu_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SEXT_W = 8
) (
  input  op_e               op,
  input  logic [WIDTH-1:0]  a,
  input  logic [WIDTH-1:0]  b,
  output logic [WIDTH-1:0]  res,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_SEXT: res = {{(WIDTH-SEXT_W){a[SEXT_W-1]}}, a[SEXT_W-1:0]};
      default: res = '0;
    endcase
  end

  always_comb begin
    if (res == '0)          flags = 3'b001;
    else if (res[WIDTH-1])  flags = 3'b010;
    else                    flags = 3'b100;
  end
endmodule

// File: rtl/cu_wr_port.sv
module cu_wr_port #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             armed,
  input  logic             produce,
  input  logic             load,
  input  logic [WIDTH-1:0] data_d,
  input  logic             go,
  output logic             req,
  output logic             fin,
  output logic [WIDTH-1:0] data_q
);
  logic             sent_q, sent_d;
  logic [WIDTH-1:0] hold_q;

  always_comb begin
    req    = armed & produce & ~sent_q;
    fin    = sent_q | ~produce | (req & go);
    data_q = hold_q;
  end

  always_comb begin
    sent_d = sent_q;
    if (start)         sent_d = 1'b0;
    else if (req & go) sent_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
      hold_q <= '0;
    end else begin
      sent_q <= sent_d;
      if (load) hold_q <= data_d;
    end
  end
endmodule

// File: rtl/cu_issue_unit.sv
module cu_issue_unit
  import cu_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SEXT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue_i,
  input  logic [1:0]               op_i,
  input  logic                     inv_a_i,
  input  logic                     zero_a_i,
  input  logic                     imm_ok_i,
  input  logic [WIDTH-1:0]         imm_i,
  input  logic                     rc_i,
  input  logic [NUM_SRC-1:0]       rdmask_i,
  input  logic [NUM_SRC-1:0]       src_go_i,
  input  logic [NUM_SRC*WIDTH-1:0] src_data_i,
  output logic                     busy_o,
  output logic [NUM_SRC-1:0]       src_req_o,
  output logic [NUM_DST-1:0]       dst_req_o,
  input  logic [NUM_DST-1:0]       dst_go_i,
  output logic [NUM_DST-1:0]       wrmask_o,
  output logic [NUM_DST*WIDTH-1:0] dst_data_o
);
  localparam int unsigned PAD_W = WIDTH - FLAG_W;

  logic             busy_q, busy_d;
  logic             alu_done_q, alu_done_d;
  ctl_t             ctl_q, ctl_d;
  logic [WIDTH-1:0] imm_q;
  logic             start, capture, finish, rd_all;

  logic [NUM_SRC-1:0] skip, rd_ready;
  logic [WIDTH-1:0]   rd_q [NUM_SRC];
  logic [NUM_DST-1:0] produce, wr_fin;
  logic [WIDTH-1:0]   wr_d [NUM_DST];

  logic [WIDTH-1:0]  opa, opb;
  logic [WIDTH-1:0]  alu_res;
  logic [FLAG_W-1:0] alu_flags;

  // issue acceptance and skip decisions
  always_comb begin
    start          = issue_i & ~busy_q;
    skip[SRC_A]    = rdmask_i[SRC_A] | ctl_q.zero_a;
    skip[SRC_B]    = rdmask_i[SRC_B] | ctl_q.imm_ok;
    rd_all         = &rd_ready;
    capture        = busy_q & ~alu_done_q & rd_all;
    produce[DST_RES] = (ctl_q.op != OP_NOP);
    produce[DST_FLG] = (ctl_q.op != OP_NOP) & ctl_q.rc;
    finish         = busy_q & alu_done_q & (&wr_fin);
  end

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rd
      cu_rd_port #(.WIDTH(WIDTH)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy_q),
        .skip  (skip[i]),
        .go    (src_go_i[i]),
        .data  (src_data_i[i*WIDTH +: WIDTH]),
        .req   (src_req_o[i]),
        .ready (rd_ready[i]),
        .q     (rd_q[i])
      );
    end
  endgenerate

  // operand substitution
  always_comb begin
    opa = ctl_q.zero_a ? '0 : rd_q[SRC_A];
    if (ctl_q.inv_a) opa = ~opa;
    opb = ctl_q.imm_ok ? imm_q : rd_q[SRC_B];
  end

  cu_alu #(.WIDTH(WIDTH), .SEXT_W(SEXT_W)) u_alu (
    .op    (ctl_q.op),
    .a     (opa),
    .b     (opb),
    .res   (alu_res),
    .flags (alu_flags)
  );

  always_comb begin
    wr_d[DST_RES] = alu_res;
    wr_d[DST_FLG] = {{PAD_W{1'b0}}, alu_flags};
  end

  generate
    for (genvar j = 0; j < NUM_DST; j++) begin : g_wr
      cu_wr_port #(.WIDTH(WIDTH)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .armed   (busy_q & alu_done_q),
        .produce (produce[j]),
        .load    (capture),
        .data_d  (wr_d[j]),
        .go      (dst_go_i[j]),
        .req     (dst_req_o[j]),
        .fin     (wr_fin[j]),
        .data_q  (dst_data_o[j*WIDTH +: WIDTH])
      );
    end
  endgenerate

  // next-state
  always_comb begin
    busy_d     = busy_q;
    alu_done_d = alu_done_q;
    ctl_d      = ctl_q;
    if (start) begin
      busy_d     = 1'b1;
      alu_done_d = 1'b0;
      ctl_d      = '{op: op_e'(op_i), inv_a: inv_a_i, zero_a: zero_a_i,
                     imm_ok: imm_ok_i, rc: rc_i};
    end else begin
      if (capture) alu_done_d = 1'b1;
      if (finish)  busy_d     = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      alu_done_q <= 1'b0;
      ctl_q      <= '0;
      imm_q      <= '0;
    end else begin
      busy_q     <= busy_d;
      alu_done_q <= alu_done_d;
      if (start) begin
        ctl_q <= ctl_d;
        imm_q <= imm_i;
      end
    end
  end

  always_comb begin
    busy_o   = busy_q;
    wrmask_o = {NUM_DST{busy_q}} & ~produce;
  end
endmodule

// File: rtl/cu_issue_unit_chk.sv
module cu_issue_unit_chk
  import cu_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SEXT_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     issue_i,
  input logic [NUM_SRC-1:0]       src_go_i,
  input logic                     busy_o,
  input logic [NUM_SRC-1:0]       src_req_o,
  input logic [NUM_DST-1:0]       dst_req_o,
  input logic [NUM_DST-1:0]       dst_go_i,
  input logic [NUM_DST-1:0]       wrmask_o,
  input logic [NUM_DST*WIDTH-1:0] dst_data_o
);
  AST_BUSY_NOT_ON_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !busy_o);  // R2
  AST_BUSY_RISE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(issue_i));  // R2
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (src_req_o == '0 && dst_req_o == '0));  // R2
  AST_MASK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_req_o & wrmask_o) == '0);  // R7

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rd_chk
      AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_o[i] && !src_go_i[i]) |=> src_req_o[i]);  // R3
      AST_RD_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req_o[i] && src_go_i[i]) |=> !src_req_o[i]);  // R4
    end
    for (genvar j = 0; j < NUM_DST; j++) begin : g_wr_chk
      AST_WR_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_req_o[j] && !dst_go_i[j]) |=>
          (dst_req_o[j] && $stable(dst_data_o[j*WIDTH +: WIDTH])));  // R8
    end
  endgenerate
endmodule

bind cu_issue_unit cu_issue_unit_chk #(.WIDTH(WIDTH), .SEXT_W(SEXT_W)) chk_i (.*);

// File: tb/cu_issue_unit_tb.sv
`timescale 1ns/1ps
module cu_issue_unit_tb_top;
  localparam int W = 16;
  localparam logic [W-1:0] IDLE_DATA = 16'hDEAD;

  typedef struct packed {
    logic [1:0]   op;
    logic         inv, za, immok, rc;
    logic [1:0]   rdm;
    logic [W-1:0] imm, a, b, e0, e1;
    logic [3:0]   da, db, d0, d1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1,1'b0,1'b0,1'b0,1'b0,2'b00,16'd0,16'd5,   16'd2,16'd7,     16'd0,4'd0,4'd2,4'd0,4'd0},
    '{2'd1,1'b0,1'b1,1'b1,1'b0,2'b00,16'd8,16'd5,   16'd2,16'd8,     16'd0,4'd0,4'd0,4'd1,4'd0},
    '{2'd1,1'b0,1'b0,1'b1,1'b0,2'b00,16'd8,16'd5,   16'd2,16'd13,    16'd0,4'd2,4'd0,4'd2,4'd0},
    '{2'd1,1'b1,1'b0,1'b0,1'b0,2'b00,16'd0,16'd5,   16'd2,16'hFFFC,  16'd0,4'd1,4'd2,4'd0,4'd0},
    '{2'd2,1'b0,1'b0,1'b0,1'b1,2'b00,16'd0,16'd5,   16'd2,16'd3,     16'd4,4'd0,4'd1,4'd2,4'd1},
    '{2'd0,1'b0,1'b0,1'b0,1'b0,2'b11,16'd0,16'd5,   16'd2,16'd0,     16'd0,4'd1,4'd2,4'd1,4'd0},
    '{2'd3,1'b0,1'b0,1'b0,1'b1,2'b10,16'd0,16'h0080,16'd2,16'hFF80,  16'd2,4'd2,4'd1,4'd0,4'd2},
    '{2'd2,1'b0,1'b0,1'b1,1'b1,2'b00,16'd5,16'd5,   16'd2,16'd0,     16'd1,4'd0,4'd1,4'd2,4'd1},
    '{2'd1,1'b0,1'b0,1'b0,1'b0,2'b01,16'd0,16'd5,   16'd9,16'd9,     16'd0,4'd3,4'd0,4'd0,4'd0},
    '{2'd3,1'b0,1'b0,1'b0,1'b1,2'b10,16'd0,16'h007F,16'd2,16'h007F,  16'd4,4'd3,4'd0,4'd1,4'd3},
    '{2'd2,1'b0,1'b0,1'b0,1'b1,2'b00,16'd0,16'd2,   16'd5,16'hFFFD,  16'd2,4'd0,4'd0,4'd0,4'd0},
    '{2'd1,1'b1,1'b1,1'b0,1'b0,2'b00,16'd0,16'd5,   16'd2,16'd1,     16'd0,4'd0,4'd0,4'd0,4'd0}
  };

  logic clk, rst_n, issue_i, inv_a_i, zero_a_i, imm_ok_i, rc_i, busy_o;
  logic [1:0] op_i, rdmask_i, src_go_i, src_req_o, dst_req_o, dst_go_i, wrmask_o;
  logic [W-1:0] imm_i;
  logic [2*W-1:0] src_data_i, dst_data_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  cu_issue_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_ok_i(imm_ok_i), .imm_i(imm_i),
    .rc_i(rc_i), .rdmask_i(rdmask_i), .src_go_i(src_go_i), .src_data_i(src_data_i),
    .busy_o(busy_o), .src_req_o(src_req_o), .dst_req_o(dst_req_o),
    .dst_go_i(dst_go_i), .wrmask_o(wrmask_o), .dst_data_o(dst_data_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    bit need_rd [2];
    bit need_wr [2];
    int dly_rd [2], dly_wr [2], wt_rd [2], wt_wr [2];
    int n_rd [2], n_wr [2];
    bit seen_rd [2], got_rd [2], rd_bad;
    logic [W-1:0] val_rd [2], exp_wr [2];
    int cyc, last_rd, first_wr, last_wr, end_cyc;
    logic [1:0] exp_mask;
    need_rd[0] = !v.rdm[0] && !v.za;
    need_rd[1] = !v.rdm[1] && !v.immok;
    need_wr[0] = (v.op != 2'd0);
    need_wr[1] = (v.op != 2'd0) && v.rc;
    exp_mask = {!need_wr[1], !need_wr[0]};
    dly_rd[0] = int'(v.da); dly_rd[1] = int'(v.db);
    dly_wr[0] = int'(v.d0); dly_wr[1] = int'(v.d1);
    val_rd[0] = v.a; val_rd[1] = v.b;
    exp_wr[0] = v.e0; exp_wr[1] = v.e1;
    for (int k = 0; k < 2; k++) begin
      wt_rd[k] = 0; wt_wr[k] = 0; n_rd[k] = 0; n_wr[k] = 0;
      seen_rd[k] = 0; got_rd[k] = 0;
    end
    rd_bad = 0; last_rd = 0; first_wr = -1; last_wr = -1; end_cyc = -1;
    // cycle 0: issue
    op_i = v.op; inv_a_i = v.inv; zero_a_i = v.za; imm_ok_i = v.immok;
    imm_i = v.imm; rc_i = v.rc; rdmask_i = v.rdm; issue_i = 1'b1;
    #1;
    check(busy_o == 1'b0, $sformatf("R2 busy low in issue cycle v%0d", idx), busy_o, 0);
    @(posedge clk); @(negedge clk);
    // scramble fields to prove capture (R1); rdmask stays held (R6)
    issue_i = 1'b0; op_i = ~v.op; inv_a_i = ~v.inv; zero_a_i = ~v.za;
    imm_ok_i = ~v.immok; imm_i = 16'h1234; rc_i = ~v.rc;
    check(busy_o == 1'b1, $sformatf("R1 busy after issue v%0d", idx), busy_o, 1);
    check(src_req_o == {need_rd[1], need_rd[0]},
          $sformatf("R3 R5 read requests after issue v%0d", idx),
          src_req_o, {need_rd[1], need_rd[0]});
    cyc = 1;
    while (cyc <= 60) begin
      if (!busy_o) begin
        end_cyc = cyc;
        break;
      end
      src_go_i = '0; dst_go_i = '0;
      src_data_i = {IDLE_DATA, IDLE_DATA};
      if (wrmask_o != exp_mask) begin
        check(0, $sformatf("R7 wrmask v%0d cyc %0d", idx, cyc), wrmask_o, exp_mask);
      end
      for (int i = 0; i < 2; i++) begin
        if (src_req_o[i]) begin
          if (got_rd[i]) rd_bad = 1;
          seen_rd[i] = 1;
          if (wt_rd[i] >= dly_rd[i]) begin
            src_go_i[i] = 1'b1;
            src_data_i[i*W +: W] = val_rd[i];
            got_rd[i] = 1; n_rd[i]++; last_rd = cyc;
          end else wt_rd[i]++;
        end else if (seen_rd[i] && !got_rd[i]) rd_bad = 1;
      end
      for (int j = 0; j < 2; j++) begin
        if (dst_req_o[j]) begin
          if (first_wr < 0) first_wr = cyc;
          if (wt_wr[j] >= dly_wr[j]) begin
            dst_go_i[j] = 1'b1; n_wr[j]++; last_wr = cyc;
            check(dst_data_o[j*W +: W] == exp_wr[j],
                  $sformatf("R8 R9 output %0d data v%0d", j, idx),
                  dst_data_o[j*W +: W], exp_wr[j]);
          end else wt_wr[j]++;
        end
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    src_go_i = '0; dst_go_i = '0; src_data_i = {IDLE_DATA, IDLE_DATA};
    check(end_cyc > 0 && end_cyc <= 50, $sformatf("R10 ends within 50 v%0d", idx), end_cyc, 50);
    check(!rd_bad, $sformatf("R3 R4 read request shape v%0d", idx), rd_bad, 0);
    for (int k = 0; k < 2; k++) begin
      check(n_rd[k] == int'(need_rd[k]), $sformatf("R5 R6 read count port %0d v%0d", k, idx),
            n_rd[k], need_rd[k]);
      check(n_wr[k] == int'(need_wr[k]), $sformatf("R7 write count port %0d v%0d", k, idx),
            n_wr[k], need_wr[k]);
    end
    if (need_wr[0]) begin
      check(first_wr == last_rd + 2, $sformatf("R10 write request timing v%0d", idx),
            first_wr, last_rd + 2);
      check(end_cyc == last_wr + 1, $sformatf("R10 busy drop timing v%0d", idx),
            end_cyc, last_wr + 1);
    end else begin
      check(end_cyc == last_rd + 3, $sformatf("R10 idle op busy drop v%0d", idx),
            end_cyc, last_rd + 3);
    end
    check(src_req_o == '0 && dst_req_o == '0, $sformatf("R2 no requests when idle v%0d", idx),
          {src_req_o, dst_req_o}, 0);
    rdmask_i = '0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; issue_i = 0; op_i = 0; inv_a_i = 0; zero_a_i = 0; imm_ok_i = 0;
    imm_i = 0; rc_i = 0; rdmask_i = 0; src_go_i = 0; dst_go_i = 0;
    src_data_i = {IDLE_DATA, IDLE_DATA};
    repeat (3) @(negedge clk);
    check(busy_o == 0 && src_req_o == 0 && dst_req_o == 0, "R2 reset state",
          {busy_o, src_req_o, dst_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // busy never rises without issue, even with grants and masks wiggling
    for (int c = 0; c < 6; c++) begin
      src_go_i = 2'(c); dst_go_i = 2'(c + 1); rdmask_i = 2'(c + 2);
      @(negedge clk);
      check(busy_o == 0 && src_req_o == 0 && dst_req_o == 0,
            "R2 idle without issue", {busy_o, src_req_o, dst_req_o}, 0);
    end
    src_go_i = 0; dst_go_i = 0; rdmask_i = 0;
    @(negedge clk);
    for (int n = 0; n < NV; n++) run_vec(VECS[n], n);
    // back-to-back issue right after completion
    run_vec(VECS[0], 100);
    run_vec(VECS[5], 101);
    summary();
  end
endmodule